// File: doc/BRIEF.md
# Scan Velocity Modulation Driver

This block turns a stream of 10-bit digital RGB pixels into an 8-bit signed drive code for the DAC that feeds a scan-velocity coil. Each accepted pixel is first reduced to a luminance value with a fixed shift-only matrix. That luminance is differenced against the sample N pixels earlier. The difference is cored so that small noise produces zero, scaled by a gain, clamped by a symmetric limiter, and then delayed by a programmable amount with half-clock resolution. The delay lets the drive line up with the beam.

Two parameter sets are presented at the ports. Each set holds a span N, a coring threshold and a gain. A per-pixel select input chooses one of the two sets, so that picture content and on-screen-display overlays can be shaped differently. The select is registered together with its pixel, so it governs exactly the pixel it accompanies. The pipeline advances only on pixels with `valid_i` high, so every latency figure below counts accepted pixels, not clock cycles.

Top module: `svm_drive`

## Requirements
- R1: Luminance is Y = floor((R + 2G + B) / 4), a 10-bit value. A gray pixel with R = G = B = v gives Y = v.
- R2: The difference is D(k) = Y(k) − Y(k−N). N is the 3-bit span field of the selected set: code 0 acts as 1, codes 7 and above act as 6, and codes 1..6 are taken as written. Pixels before the first one after reset count as Y = 0.
- R3: Coring uses the 8-bit threshold T of the selected set. If |D| ≤ T the result is 0. Otherwise the result is D − T for positive D and D + T for negative D.
- R4: The gain G is the 6-bit unsigned field of the selected set. The scaled value is floor(C·G / 16), so G = 16 is unity gain and G = 0 gives zero.
- R5: The scaled value is clamped to the range [−L, +L], where L is the 7-bit `limit_i`. With L = 0 the output is always 0.
- R6: `set_sel_i` = 1 applies set 1 and `set_sel_i` = 0 applies set 0. The choice applies to the span, coring and gain of the very pixel that the select accompanies.
- R7: `delay_i` is a 4-bit two's-complement code d in half-pixel steps, and −8 acts as −7. Let h = d + 8. For even h, after pixel m is accepted the output is the limited value of pixel m − 3 − h/2. For odd h, the output is the floor average of the limited values of pixels m − 3 − (h−1)/2 and m − 3 − (h+1)/2. Code 0 therefore gives a nominal latency of 7 pixels.
- R8: A cycle with `valid_i` low changes no state, and `svm_o` holds its value.
- R9: After reset `svm_o` is 0 and all history is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Pixel strobe; pipeline advances when high |
| red_i | input | 10 | Red component |
| grn_i | input | 10 | Green component |
| blu_i | input | 10 | Blue component |
| set_sel_i | input | 1 | Parameter set select for this pixel |
| span0_i | input | 3 | Set 0 difference span N |
| core0_i | input | 8 | Set 0 coring threshold |
| gain0_i | input | 6 | Set 0 gain (16 = unity) |
| span1_i | input | 3 | Set 1 difference span N |
| core1_i | input | 8 | Set 1 coring threshold |
| gain1_i | input | 6 | Set 1 gain (16 = unity) |
| limit_i | input | 7 | Symmetric output limit |
| delay_i | input | 4 | Output delay in signed half-pixel steps |
| svm_o | output | 8 | Signed drive code |

## Verification
A corrupted luminance history entry shows up as a wrong difference for exactly the pixel that is N pixels later. It then reaches the port 7 ± 3.5 accepted pixels after that. A wrong set select or wrong threshold appears only on pixels whose difference lies near the coring edge or inside the limiter range. For this reason the stimulus mixes random spans, thresholds and selects with directed steps at |D| = T and T + 1. A fault in the delay tap or the averaging shows up at once as a half-step offset, and every delay code is swept.

// File: rtl/svm_pkg.sv
package svm_pkg;
  localparam int SPAN_W = 3;
  localparam int CORE_W = 8;
  localparam int GAIN_W = 6;
  localparam int GAIN_FRAC = 4;
  localparam int CODE_W = 4;
endpackage

// File: rtl/svm_luma_diff.sv
module svm_luma_diff
  import svm_pkg::*;
#(
  parameter int PIX_W = 10,
  parameter int MAX_SPAN = 6,
  localparam int DW = PIX_W + 1,
  localparam int IDX_W = (MAX_SPAN > 1) ? $clog2(MAX_SPAN) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [PIX_W-1:0]     r_i,
  input  logic [PIX_W-1:0]     g_i,
  input  logic [PIX_W-1:0]     b_i,
  input  logic                 sel_i,
  input  logic [SPAN_W-1:0]    span0_i,
  input  logic [SPAN_W-1:0]    span1_i,
  output logic signed [DW-1:0] diff_o,
  output logic                 sel_o
);
  logic [PIX_W+1:0]  sum;
  logic [PIX_W-1:0]  y_q;
  logic [PIX_W-1:0]  hist_q [MAX_SPAN];
  logic              sel_q;
  logic [SPAN_W-1:0] span_raw, span_eff;
  logic [IDX_W-1:0]  idx;

  assign sum = {2'b00, r_i} + {1'b0, g_i, 1'b0} + {2'b00, b_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q   <= '0;
      sel_q <= 1'b0;
      for (int i = 0; i < MAX_SPAN; i++) hist_q[i] <= '0;
    end else if (en_i) begin
      y_q       <= sum[PIX_W+1:2];
      sel_q     <= sel_i;
      hist_q[0] <= y_q;
      for (int i = 1; i < MAX_SPAN; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  // out-of-range span codes clamp to the nearest legal span
  always_comb begin
    span_raw = sel_q ? span1_i : span0_i;
    if (span_raw == '0) span_eff = SPAN_W'(1);
    else if (span_raw > SPAN_W'(MAX_SPAN)) span_eff = SPAN_W'(MAX_SPAN);
    else span_eff = span_raw;
    idx = IDX_W'(span_eff - SPAN_W'(1));
  end

  assign diff_o = $signed({1'b0, y_q}) - $signed({1'b0, hist_q[idx]});
  assign sel_o  = sel_q;

  assert_sel_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(sel_q) && $stable(y_q));
endmodule

// File: rtl/svm_shape.sv
module svm_shape
  import svm_pkg::*;
#(
  parameter int DW = 11,
  parameter int OUT_W = 8,
  localparam int PW = DW + GAIN_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [DW-1:0]    diff_i,
  input  logic                    sel_i,
  input  logic [CORE_W-1:0]       core0_i,
  input  logic [CORE_W-1:0]       core1_i,
  input  logic [GAIN_W-1:0]       gain0_i,
  input  logic [GAIN_W-1:0]       gain1_i,
  input  logic [OUT_W-2:0]        limit_i,
  output logic signed [OUT_W-1:0] lim_o
);
  logic [DW-1:0]           mag, thr;
  logic signed [DW-1:0]    cored, c_q;
  logic [GAIN_W-1:0]       g_q;
  logic signed [PW-1:0]    prod, scaled, lim_v, sat;
  logic signed [OUT_W-1:0] lim_q;

  always_comb begin
    mag = diff_i[DW-1] ? DW'(-diff_i) : DW'(diff_i);
    thr = {{(DW-CORE_W){1'b0}}, (sel_i ? core1_i : core0_i)};
    if (mag <= thr) cored = '0;
    else if (diff_i[DW-1]) cored = diff_i + $signed(thr);
    else cored = diff_i - $signed(thr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q <= '0;
      g_q <= '0;
    end else if (en_i) begin
      c_q <= cored;
      g_q <= sel_i ? gain1_i : gain0_i;
    end
  end

  always_comb begin
    prod   = c_q * $signed({1'b0, g_q});
    scaled = prod >>> GAIN_FRAC;
    lim_v  = $signed({{(PW-OUT_W+1){1'b0}}, limit_i});
    if (scaled > lim_v) sat = lim_v;
    else if (scaled < -lim_v) sat = -lim_v;
    else sat = scaled;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lim_q <= '0;
    else if (en_i) lim_q <= sat[OUT_W-1:0];
  end

  assign lim_o = lim_q;

  assert_core_dead_zone_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mag <= thr) |=> (c_q == '0));
  assert_core_shrinks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ((c_q[DW-1] ? DW'(-c_q) : DW'(c_q)) <= $past(mag)));
  assert_limit_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (lim_q <= $signed({1'b0, $past(limit_i)}))
          && (lim_q >= -$signed({1'b0, $past(limit_i)})));
endmodule

// File: rtl/svm_delay.sv
module svm_delay
  import svm_pkg::*;
#(
  parameter int W = 8,
  localparam int NTAP = (1 << (CODE_W - 1)) + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic signed [W-1:0] d_i,
  input  logic [CODE_W-1:0]   code_i,
  output logic signed [W-1:0] q_o
);
  logic signed [W-1:0] dl_q [NTAP-1];
  logic signed [W-1:0] tap  [NTAP];
  logic [CODE_W-1:0]   h;
  logic [CODE_W-2:0]   lo;
  logic [CODE_W-1:0]   hi;
  logic signed [W:0]   pair;
  logic signed [W-1:0] pick, q_q;

  assign tap[0] = d_i;
  for (genvar j = 1; j < NTAP; j++) begin : g_tap
    assign tap[j] = dl_q[j-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NTAP - 1; i++) dl_q[i] <= '0;
    end else if (en_i) begin
      dl_q[0] <= d_i;
      for (int i = 1; i < NTAP - 1; i++) dl_q[i] <= dl_q[i-1];
    end
  end

  // h = code + centre, in half steps; the most negative code folds onto its neighbour
  always_comb begin
    h = code_i ^ {1'b1, {(CODE_W-1){1'b0}}};
    if (h == '0) h = CODE_W'(1);
    lo   = h[CODE_W-1:1];
    hi   = {1'b0, lo} + CODE_W'(1);
    pair = {tap[lo][W-1], tap[lo]} + {tap[hi][W-1], tap[hi]};
    pick = h[0] ? pair[W:1] : tap[lo];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else if (en_i) q_q <= pick;
  end

  assign q_o = q_q;

  assert_out_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_q));
  assert_reset_zero_R9: assert property (@(posedge clk_i)
    !rst_ni |-> (q_q == '0));
endmodule

// File: rtl/svm_drive.sv
module svm_drive
  import svm_pkg::*;
#(
  parameter int PIX_W = 10,
  parameter int OUT_W = 8,
  parameter int MAX_SPAN = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [PIX_W-1:0]    red_i,
  input  logic [PIX_W-1:0]    grn_i,
  input  logic [PIX_W-1:0]    blu_i,
  input  logic                set_sel_i,
  input  logic [SPAN_W-1:0]   span0_i,
  input  logic [CORE_W-1:0]   core0_i,
  input  logic [GAIN_W-1:0]   gain0_i,
  input  logic [SPAN_W-1:0]   span1_i,
  input  logic [CORE_W-1:0]   core1_i,
  input  logic [GAIN_W-1:0]   gain1_i,
  input  logic [OUT_W-2:0]    limit_i,
  input  logic [CODE_W-1:0]   delay_i,
  output logic [OUT_W-1:0]    svm_o
);
  localparam int DW = PIX_W + 1;

  logic signed [DW-1:0]    diff;
  logic                    sel_q;
  logic signed [OUT_W-1:0] lim, q;

  svm_luma_diff #(.PIX_W(PIX_W), .MAX_SPAN(MAX_SPAN)) i_luma_diff (
    .clk_i, .rst_ni, .en_i(valid_i),
    .r_i(red_i), .g_i(grn_i), .b_i(blu_i), .sel_i(set_sel_i),
    .span0_i, .span1_i, .diff_o(diff), .sel_o(sel_q)
  );

  svm_shape #(.DW(DW), .OUT_W(OUT_W)) i_shape (
    .clk_i, .rst_ni, .en_i(valid_i), .diff_i(diff), .sel_i(sel_q),
    .core0_i, .core1_i, .gain0_i, .gain1_i, .limit_i, .lim_o(lim)
  );

  svm_delay #(.W(OUT_W)) i_delay (
    .clk_i, .rst_ni, .en_i(valid_i), .d_i(lim), .code_i(delay_i), .q_o(q)
  );

  assign svm_o = q;
endmodule

// File: tb/test_svm_drive.sv
module test_svm_drive;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [9:0] red_i = '0, grn_i = '0, blu_i = '0;
  logic       set_sel_i = 1'b0;
  logic [2:0] span0_i = 3'd1, span1_i = 3'd1;
  logic [7:0] core0_i = '0, core1_i = '0;
  logic [5:0] gain0_i = 6'd16, gain1_i = 6'd16;
  logic [6:0] limit_i = 7'd127;
  logic [3:0] delay_i = '0;
  logic [7:0] svm_o;

  svm_drive i_svm_drive (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  int cnt = 0, last_cfg = -100;
  int yarr [0:8191];
  int larr [0:8191];
  string tag = "R9";

  function automatic int yget(int i);
    return (i < 0) ? 0 : yarr[i];
  endfunction
  function automatic int lget(int i);
    return (i < 0) ? 0 : larr[i];
  endfunction
  function automatic int span_eff(int s);
    if (s == 0) return 1;
    if (s > 6) return 6;
    return s;
  endfunction
  function automatic int model_l(int k, int sel);
    int n, t, g, d, c, s, lm;
    n = span_eff(sel ? int'(span1_i) : int'(span0_i));
    t = sel ? int'(core1_i) : int'(core0_i);
    g = sel ? int'(gain1_i) : int'(gain0_i);
    d = yget(k) - yget(k - n);
    if (d <= t && d >= -t) c = 0;
    else if (d > 0) c = d - t;
    else c = d + t;
    s = (c * g) >>> 4;
    lm = int'(limit_i);
    if (s > lm) s = lm;
    if (s < -lm) s = -lm;
    return s;
  endfunction
  function automatic int expect_out(int m);
    int dc, h;
    dc = int'($signed(delay_i));
    if (dc == -8) dc = -7;
    h = dc + 8;
    if (h % 2 == 0) return lget(m - 3 - h / 2);
    return (lget(m - 3 - (h - 1) / 2) + lget(m - 3 - (h + 1) / 2)) >>> 1;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (pixel %0d)", req, act, exp, cnt);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic push(int r, int g, int b, int sel);
    int m;
    valid_i = 1'b1; red_i = 10'(r); grn_i = 10'(g); blu_i = 10'(b);
    set_sel_i = sel[0];
    @(posedge clk_i);
    m = cnt;
    yarr[m] = (r + 2 * g + b) >> 2;
    larr[m] = model_l(m, sel);
    cnt++;
    @(negedge clk_i);
    valid_i = 1'b0;
    if (m >= last_cfg + 12)
      check(tag, int'($signed(svm_o)), expect_out(m));
  endtask

  task automatic stall();
    int prev;
    prev = int'($signed(svm_o));
    valid_i = 1'b0;
    red_i = 10'($urandom); set_sel_i = ~set_sel_i;
    @(posedge clk_i);
    @(negedge clk_i);
    check("R8", int'($signed(svm_o)), prev);
  endtask

  task automatic gray(int v, int sel);
    push(v, v, v, sel);
  endtask

  task automatic rand_run(int n, bit rand_sel, bit stalls);
    for (int i = 0; i < n; i++) begin
      if (stalls && ($urandom % 8) == 0) stall();
      push(int'($urandom % 1024), int'($urandom % 1024), int'($urandom % 1024),
           rand_sel ? int'($urandom % 2) : 0);
    end
  endtask

  task automatic cfg_mark();
    last_cfg = cnt;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    check("R9", int'($signed(svm_o)), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9", int'($signed(svm_o)), 0);

    // R9 and R1: early pixels against zero history, unity shaping, span 1
    tag = "R1";
    for (int i = 0; i < 40; i++) gray(int'($urandom % 1024), 0);
    rand_run(150, 1'b0, 1'b0);

    // R6: two distinct sets, per-pixel select, with stalls (R8)
    span0_i = 3'd1; core0_i = 8'd4;  gain0_i = 6'd20;
    span1_i = 3'd4; core1_i = 8'd30; gain1_i = 6'd40;
    cfg_mark(); tag = "R6";
    rand_run(400, 1'b1, 1'b1);

    // R6 directed: a step whose size lies between the two thresholds
    span0_i = 3'd1; core0_i = 8'd50; gain0_i = 6'd16;
    span1_i = 3'd1; core1_i = 8'd0;  gain1_i = 6'd16;
    cfg_mark();
    for (int i = 0; i < 14; i++) gray(200, 0);
    for (int i = 0; i < 20; i++) begin gray(230, 1); gray(200, 0); gray(230, 0); gray(200, 1); end

    // R2: span code clamping (0 -> 1, 7 -> 6) and other spans
    span0_i = 3'd0; span1_i = 3'd7; core0_i = 8'd0; core1_i = 8'd0;
    gain0_i = 6'd8; gain1_i = 6'd8;
    cfg_mark(); tag = "R2";
    rand_run(200, 1'b1, 1'b0);
    span0_i = 3'd5; span1_i = 3'd2;
    cfg_mark();
    rand_run(200, 1'b1, 1'b1);

    // R3: coring boundary, |D| = T gives 0, |D| = T + 1 gives +/-1
    span0_i = 3'd1; core0_i = 8'd20; gain0_i = 6'd16; limit_i = 7'd127;
    cfg_mark(); tag = "R3";
    for (int i = 0; i < 14; i++) gray(500, 0);
    for (int i = 0; i < 10; i++) begin
      gray(520, 0); gray(500, 0); gray(521, 0); gray(500, 0); gray(479, 0); gray(500, 0);
    end
    for (int i = 0; i < 12; i++) gray(500, 0);
    core0_i = 8'($urandom % 64); cfg_mark();
    rand_run(150, 1'b0, 1'b0);

    // R4: gain zero and gain values across the range
    tag = "R4";
    core0_i = 8'd0; gain0_i = 6'd0; cfg_mark();
    rand_run(60, 1'b0, 1'b0);
    for (int gsel = 1; gsel < 64; gsel += 13) begin
      gain0_i = 6'(gsel); limit_i = 7'd127; cfg_mark();
      for (int i = 0; i < 40; i++) gray(int'($urandom % 60) + 400, 0);
    end

    // R5: limiter saturation and limit 0
    tag = "R5";
    gain0_i = 6'd63; limit_i = 7'd5; cfg_mark();
    rand_run(150, 1'b0, 1'b1);
    limit_i = 7'd0; cfg_mark();
    rand_run(60, 1'b0, 1'b0);
    limit_i = 7'd127; cfg_mark();
    rand_run(100, 1'b0, 1'b0);

    // R7: every delay code, including the folded -8
    tag = "R7";
    gain0_i = 6'd16; span0_i = 3'd2; core0_i = 8'd2; limit_i = 7'd100; cfg_mark();
    rand_run(20, 1'b0, 1'b0);
    for (int dc = -8; dc < 8; dc++) begin
      delay_i = 4'(dc);
      rand_run(40, 1'b1, 1'b1);
    end
    delay_i = 4'd0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule